// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

A memory-mapped watchdog counts down from a programmable start value on each cycle where a count-enable tick is high. Software proves that it is alive by writing a fixed key word to a restart register before the count reaches zero. If the count does reach zero, an expiry flag is latched. That flag can drive three level outputs: an interrupt, a system reset request and an external signal. Each output has its own enable bit in the control register.

The block sits on a simple 32-bit register bus that takes whole words only. The bus has a byte address, a write strobe, write data and a combinational read path. The expiry flag is cleared by writing ones to a separate clear register. The control register also holds a clock-select bit. The block stores that bit and reads it back, but the bit has no effect inside the block.

Top module: `watchdog_mmr`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the start-value register reads 0x03EF1480, the identification word at offset 0x1C reads 0x00010601, and all three outputs are low.
- R2: Register offsets are as follows. Offset 0x04 holds the 32-bit start value. Offset 0x0C holds control bits [4:0]: bit 0 enable, bit 1 reset request, bit 2 interrupt, bit 3 external signal, bit 4 clock select. Offset 0x18 holds an 8-bit interrupt-length value. Each of these reads back what was last written, with unused bits zero.
- R3: Writing control with bit 0 set while bit 0 was clear loads the count from the start value. Writing control while bit 0 is already set leaves the count unchanged. While bit 0 is clear, ticks neither change anything visible nor cause an expiry.
- R4: While enabled, the count falls by one on each cycle where tick is high and the count is nonzero. With tick low, the count holds.
- R5: A write of exactly 0x00005AB9 to offset 0x08 while enabled reloads the count from the start value. Any other value written there leaves the count unchanged.
- R6: On the tick that takes the count from 1 to 0, status bit 1 (offset 0x10) is set. The count then stays at 0 until it is reloaded.
- R7: While status bit 1 is set, the reset request, interrupt and external outputs equal control bits 1, 2 and 3 respectively. All three are low while status bit 1 is clear.
- R8: Writing to offset 0x14 clears each status bit written as 1 and leaves bits written as 0. If an expiry falls in the same cycle as a clear, the expiry wins.
- R9: Reading offset 0x00 returns the start value while disabled. While enabled, it returns the smaller of the remaining count and the start value.
- R10: Writes to offsets 0x00 and 0x1C, to unaligned addresses, or to addresses at 0x20 and above have no effect. Reads of unaligned or unmapped addresses, and of offsets 0x08 and 0x14, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tick | input | 1 | Count enable; one decrement per high cycle |
| irq_o | output | 1 | Interrupt level on expiry |
| rst_req_o | output | 1 | System reset request level on expiry |
| ext_o | output | 1 | External signal level on expiry |

## Verification
A wrong count shows up at the counter offset on the same cycle that it is read. It also shows up as an expiry that comes one or more ticks early or late on the three outputs. A bad enable or reload decision shows as a counter read that does not fall back to the start value. An expiry flag that is stuck or lost shows on the next cycle as output levels that do not follow control bits 1 to 3. A reference model in the bench compares the read data and all three outputs after every single cycle. The bench drives randomised sequences of restarts, control rewrites, start-value changes and clears, so any divergence is caught within one cycle of the faulty update.

// File: rtl/watchdog_mmr.sv
module watchdog_mmr #(
  parameter int          ADDR_W    = 8,
  parameter int          ILEN_W    = 8,
  parameter logic [31:0] LOAD_INIT = 32'h03EF_1480,
  parameter logic [31:0] KICK_KEY  = 32'h0000_5AB9,
  parameter logic [31:0] ID_WORD   = 32'h0001_0601
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic              ext_o
);
  localparam int CTRL_W = 5;

  logic [31:0]       load, cnt;
  logic [CTRL_W-1:0] ctrl;
  logic [ILEN_W-1:0] ilen;
  logic              expired;

  logic       mapped;
  logic [2:0] sel;
  assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:5] == '0);
  assign sel    = bus_addr[4:2];

  logic wr_load, wr_kick, wr_ctrl, wr_clr, wr_ilen;
  assign wr_load = bus_we && mapped && sel == 3'd1;
  assign wr_kick = bus_we && mapped && sel == 3'd2;
  assign wr_ctrl = bus_we && mapped && sel == 3'd3;
  assign wr_clr  = bus_we && mapped && sel == 3'd5;
  assign wr_ilen = bus_we && mapped && sel == 3'd6;

  logic start, kick, step, fire;
  assign start = wr_ctrl && bus_wdata[0] && !ctrl[0];
  assign kick  = wr_kick && ctrl[0] && bus_wdata == KICK_KEY;
  assign step  = ctrl[0] && tick && cnt != '0 && !start && !kick;
  assign fire  = step && cnt == 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load    <= LOAD_INIT;
      cnt     <= LOAD_INIT;
      ctrl    <= '0;
      ilen    <= '0;
      expired <= 1'b0;
    end else begin
      if (wr_load) load <= bus_wdata;
      if (wr_ctrl) ctrl <= bus_wdata[CTRL_W-1:0];
      if (wr_ilen) ilen <= bus_wdata[ILEN_W-1:0];
      if (start || kick) cnt <= load;
      else if (step)     cnt <= cnt - 32'd1;
      if (fire)                      expired <= 1'b1;
      else if (wr_clr && bus_wdata[1]) expired <= 1'b0;
    end
  end

  logic [31:0] live;
  assign live = !ctrl[0] ? load : (cnt < load ? cnt : load);

  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      case (sel)
        3'd0: bus_rdata = live;
        3'd1: bus_rdata = load;
        3'd3: bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl};
        3'd4: bus_rdata = {30'd0, expired, 1'b0};
        3'd6: bus_rdata = {{(32-ILEN_W){1'b0}}, ilen};
        3'd7: bus_rdata = ID_WORD;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign rst_req_o = expired && ctrl[1];
  assign irq_o     = expired && ctrl[2];
  assign ext_o     = expired && ctrl[3];
endmodule

// File: rtl/watchdog_mmr_chk.sv
module watchdog_mmr_chk #(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] KICK_KEY = 32'h0000_5AB9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              tick,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              ext_o,
  input logic [31:0]       cnt,
  input logic [31:0]       load,
  input logic [4:0]        ctrl
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(20);

  logic quiet;
  assign quiet = !(bus_we && (bus_addr == A_CTRL || bus_addr == A_KICK));

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && tick && quiet && cnt != 0 |=> cnt == $past(cnt) - 32'd1); // R4

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] && quiet |=> $stable(cnt)); // R3

  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_KICK && bus_wdata == KICK_KEY && ctrl[0]
    |=> cnt == $past(load)); // R5

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_KICK && bus_wdata != KICK_KEY && !tick
    |=> $stable(cnt)); // R5

  AST_EXPIRY_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && tick && quiet && cnt == 32'd1
    |=> cnt == 0 && rst_req_o == ctrl[1] && irq_o == ctrl[2] && ext_o == ctrl[3]); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_CLR && bus_wdata[1] && !(ctrl[0] && tick && cnt == 32'd1)
    |=> !irq_o && !rst_req_o && !ext_o); // R8

  AST_READ_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == A_CNT |-> bus_rdata <= load); // R9
endmodule

bind watchdog_mmr watchdog_mmr_chk #(.ADDR_W(ADDR_W), .KICK_KEY(KICK_KEY)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .irq_o(irq_o),
  .rst_req_o(rst_req_o), .ext_o(ext_o), .cnt(cnt), .load(load), .ctrl(ctrl)
);

// File: tb/watchdog_mmr_tb_top.sv
module watchdog_mmr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic        irq_o, rst_req_o, ext_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  watchdog_mmr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .irq_o(irq_o), .rst_req_o(rst_req_o), .ext_o(ext_o)
  );

  int errors = 0;
  int checks = 0;

  logic [31:0] m_load = 32'h03EF_1480;
  logic [31:0] m_cnt  = 32'h03EF_1480;
  logic [4:0]  m_ctrl = '0;
  logic [7:0]  m_ilen = '0;
  logic        m_st   = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a[1:0] != 2'b00 || a[7:5] != 3'd0) return 32'd0;
    case (a[4:2])
      3'd0: return !m_ctrl[0] ? m_load : (m_cnt < m_load ? m_cnt : m_load);
      3'd1: return m_load;
      3'd3: return {27'd0, m_ctrl};
      3'd4: return {30'd0, m_st, 1'b0};
      3'd6: return {24'd0, m_ilen};
      3'd7: return 32'h0001_0601;
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_step(bit we, logic [7:0] a, logic [31:0] d, bit tk);
    bit ok, st_, kk, sp, fr;
    ok  = (a[1:0] == 2'b00) && (a[7:5] == 3'd0);
    st_ = we && ok && a[4:2] == 3'd3 && d[0] && !m_ctrl[0];
    kk  = we && ok && a[4:2] == 3'd2 && m_ctrl[0] && d == 32'h5AB9;
    sp  = m_ctrl[0] && tk && m_cnt != 0 && !st_ && !kk;
    fr  = sp && m_cnt == 1;
    if (st_ || kk) m_cnt = m_load;
    else if (sp)   m_cnt = m_cnt - 1;
    if (fr) m_st = 1'b1;
    else if (we && ok && a[4:2] == 3'd5 && d[1]) m_st = 1'b0;
    if (we && ok && a[4:2] == 3'd1) m_load = d;
    if (we && ok && a[4:2] == 3'd3) m_ctrl = d[4:0];
    if (we && ok && a[4:2] == 3'd6) m_ilen = d[7:0];
  endtask

  task automatic op(string tag, bit we, logic [7:0] a, logic [31:0] d, bit tk);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
    m_step(we, a, d, tk);
    @(posedge clk);
    #1;
    chk({tag, " rdata"}, bus_rdata, m_read(a));
    chk({tag, " R7 irq"}, {31'd0, irq_o}, {31'd0, m_st & m_ctrl[2]});
    chk({tag, " R7 rst_req"}, {31'd0, rst_req_o}, {31'd0, m_st & m_ctrl[1]});
    chk({tag, " R7 ext"}, {31'd0, ext_o}, {31'd0, m_st & m_ctrl[3]});
  endtask

  task automatic rd(string tag, logic [7:0] a);
    op(tag, 1'b0, a, 32'd0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7321);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values, with literal expectations as well
    #1;
    chk("R1 irq at reset", {31'd0, irq_o}, 32'd0);
    chk("R1 rst_req at reset", {31'd0, rst_req_o}, 32'd0);
    rd("R1 id", 8'h1C);      chk("R1 id literal", bus_rdata, 32'h0001_0601);
    rd("R1 load", 8'h04);    chk("R1 load literal", bus_rdata, 32'h03EF_1480);
    rd("R1 ctrl", 8'h0C);
    rd("R1 status", 8'h10);
    rd("R1 R9 counter", 8'h00);

    // R2 register read-back
    op("R2 load wr", 1, 8'h04, 32'd20, 0);  chk("R2 load literal", bus_rdata, 32'd20);
    op("R2 ilen wr", 1, 8'h18, 32'h1AB, 0); chk("R2 ilen literal", bus_rdata, 32'hAB);
    op("R2 ctrl wr", 1, 8'h0C, 32'hFFFF_FFFE, 0); chk("R2 ctrl literal", bus_rdata, 32'h1E);
    op("R2 ctrl off", 1, 8'h0C, 32'd0, 0);

    // R10 ignored writes and empty reads
    op("R10 wr counter", 1, 8'h00, 32'd5, 0);
    op("R10 wr id", 1, 8'h1C, 32'h1234, 0);
    op("R10 wr high", 1, 8'h24, 32'd3, 0);
    op("R10 wr unaligned", 1, 8'h05, 32'd0, 0);
    rd("R10 load kept", 8'h04); chk("R10 load literal", bus_rdata, 32'd20);
    rd("R10 id kept", 8'h1C);
    rd("R10 rd high", 8'h20);
    rd("R10 rd unaligned", 8'h06);
    rd("R10 rd kick", 8'h08);
    rd("R10 rd clear", 8'h14);

    // R3 R4 start, run, rewrite, stop
    op("R3 load", 1, 8'h04, 32'd10, 0);
    op("R3 enable", 1, 8'h0C, 32'd1, 0);
    op("R4 hold", 0, 8'h00, 0, 0);
    for (int i = 0; i < 3; i++) op("R4 tick", 0, 8'h00, 0, 1);
    chk("R4 count literal", bus_rdata, 32'd7);
    op("R3 rewrite running", 1, 8'h0C, 32'h0F, 0);
    rd("R3 no restart", 8'h00); chk("R3 count literal", bus_rdata, 32'd7);
    op("R3 disable", 1, 8'h0C, 32'd0, 0);
    for (int i = 0; i < 15; i++) op("R3 idle ticks", 0, 8'h10, 0, 1);
    op("R3 re-enable", 1, 8'h0C, 32'd1, 0);
    rd("R3 from load", 8'h00); chk("R3 from load literal", bus_rdata, 32'd10);

    // R9 cap at start value
    op("R9 shrink load", 1, 8'h04, 32'd4, 0);
    rd("R9 capped", 8'h00); chk("R9 capped literal", bus_rdata, 32'd4);
    op("R9 restore load", 1, 8'h04, 32'd10, 0);

    // R5 restart key
    op("R5 tick", 0, 8'h00, 0, 1);
    op("R5 tick", 0, 8'h00, 0, 1);
    op("R5 near key", 1, 8'h08, 32'h5AB8, 0);
    op("R5 wide key", 1, 8'h08, 32'h1_5AB9, 0);
    rd("R5 unchanged", 8'h00); chk("R5 unchanged literal", bus_rdata, 32'd8);
    op("R5 key", 1, 8'h08, 32'h5AB9, 0);
    rd("R5 reloaded", 8'h00); chk("R5 reloaded literal", bus_rdata, 32'd10);

    // R6 R7 expiry with only reset request enabled
    op("R7 ctrl rst only", 1, 8'h0C, 32'h03, 0);
    op("R6 load 3", 1, 8'h04, 32'd3, 0);
    op("R6 key", 1, 8'h08, 32'h5AB9, 0);
    for (int i = 0; i < 3; i++) op("R6 tick", 0, 8'h00, 0, 1);
    chk("R7 rst_req literal", {31'd0, rst_req_o}, 32'd1);
    chk("R7 irq masked literal", {31'd0, irq_o}, 32'd0);
    for (int i = 0; i < 4; i++) op("R6 hold zero", 0, 8'h00, 0, 1);
    rd("R6 status", 8'h10); chk("R6 status literal", bus_rdata, 32'd2);
    op("R7 enable all", 1, 8'h0C, 32'h0F, 0);

    // R8 clear semantics
    op("R8 clear other bit", 1, 8'h14, 32'h1, 0);
    chk("R8 still set literal", {31'd0, irq_o}, 32'd1);
    op("R8 clear", 1, 8'h14, 32'h2, 0);
    chk("R8 cleared literal", {31'd0, ext_o}, 32'd0);
    op("R8 key", 1, 8'h08, 32'h5AB9, 0);
    op("R8 tick", 0, 8'h00, 0, 1);
    op("R8 tick", 0, 8'h00, 0, 1);
    op("R8 clear vs expiry", 1, 8'h14, 32'h2, 1);
    chk("R8 expiry wins literal", {31'd0, irq_o}, 32'd1);
    op("R8 clear", 1, 8'h14, 32'hFFFF_FFFF, 0);
    op("R3 off", 1, 8'h0C, 32'd0, 0);

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      int p;
      bit tk;
      logic [7:0] ra;
      p  = $urandom_range(0, 99);
      tk = ($urandom_range(0, 9) < 7);
      ra = {3'd0, 3'($urandom_range(0, 7)), 2'b00};
      if (p < 45)      op("R4 rnd idle", 0, ra, 0, tk);
      else if (p < 60) op("R5 rnd key", 1, 8'h08, 32'h5AB9, tk);
      else if (p < 64) op("R5 rnd bad key", 1, 8'h08, 32'($urandom_range(0, 32'hFFFF)), tk);
      else if (p < 72) op("R3 rnd ctrl", 1, 8'h0C, 32'($urandom_range(0, 31)) | 32'(p & 1), tk);
      else if (p < 80) op("R8 rnd clear", 1, 8'h14, 32'($urandom_range(0, 3)), tk);
      else if (p < 86) op("R9 rnd load", 1, 8'h04, 32'($urandom_range(1, 24)), tk);
      else if (p < 92) op("R10 rnd stray", 1, 8'($urandom_range(0, 255)) | 8'h20, $urandom, tk);
      else             op("R9 rnd counter", 0, 8'h00, 0, tk);
    end

    finish_run();
  end
endmodule